// File: doc/BRIEF.md
# Indexed Display-Controller Register Port

This block is the processor-facing side of a character display controller. A processor reaches it through a 16-bit I/O port address. One address bit acts as an active-low chip select. Two further bits choose among four functions: load the pointer, write data, read status and read data. The pointer is a 5-bit index. It names one of eighteen configuration registers, and the data port then reaches the register it names.

Every write is trimmed to the width that its register implements. The stored values drive a flat configuration bus that feeds the timing, cursor and light-pen logic, which sit outside this block. The last two registers hold a captured light-pen address. Only a strobe from the light-pen logic can load them, so the processor can never write them.

Readback depends on a variant input that selects one of five controller flavours. The variant decides which registers read back their contents, which read as fixed constants, and which are not decoded at all. It also decides whether the status port exists, and whether it mirrors the data port. Read data and its valid flag are combinational, so a read completes in the same cycle as the access.

Top module: `crtc_regif`

## Requirements
- R1: An access is decoded only when `port_addr_i[14]` is 0. Bits 9:8 give the function: 00 pointer write, 01 data write, 10 status read, 11 data read. With bit 14 at 1, a write changes no register and a read leaves `rdata_vld_o` low. A read strobe on a write function (00 or 01) is not decoded.
- R2: A pointer write stores bits 4:0 of `wdata_i`. Bits 7:5 are discarded.
- R3: A data write keeps only the implemented bits of the addressed register. Registers 0–3 and 13 keep 8 bits. Registers 5, 9 and 11 keep 5 bits. Registers 12 and 14 keep 6 bits. Registers 4, 6, 7 and 10 keep 7 bits. Register 8 keeps 2 bits. Bits above the kept width store 0.
- R4: Data writes to registers 16 and 17 are ignored on every variant. A cycle with `lp_strobe_i` high loads register 16 with `lp_addr_i[13:8]` (upper bits 0) and register 17 with `lp_addr_i[7:0]`.
- R5: A data read of registers 0–11 returns 0 with valid high on variants 0 and 1. On variants 2, 3 and 4 the read is not decoded.
- R6: A data read of registers 12 and 13 returns the stored value on variants 0, 3 and 4. It returns 0 on variants 1 and 2. Valid is high in all cases.
- R7: A data read of registers 14–17 returns the stored value, with valid high, on every variant.
- R8: A data read of pointer values 18–30 returns 0 on variants 0, 1 and 2. For pointer value 31, it returns 0xFF on variant 1 and 0 on variants 0 and 2. On variants 3 and 4, pointer values 18–31 are not decoded.
- R9: A status read is not decoded on variants 0 and 2. It returns 0 with valid high on variant 1. On variants 3 and 4 it returns exactly what a data read would return.
- R10: A synchronous active-high `rst` clears the pointer and all eighteen registers to 0. Valid is low whenever `rd_en_i` is low.
- R11: Register n appears on `cfg_o[8n+7:8n]`. The new value is visible from the clock edge that accepts the write.
- R12: `rdata_o` is 0 whenever `rdata_vld_o` is low. Variant codes 5–7 behave as variant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| variant_i | input | 3 | Controller flavour, 0–4 |
| port_addr_i | input | 16 | I/O port address |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| rdata_vld_o | output | 1 | High when the read was decoded |
| lp_strobe_i | input | 1 | Light-pen capture load |
| lp_addr_i | input | 14 | Captured refresh address |
| cfg_o | output | 144 | Stored registers, 8 bits each, register 0 in the low byte |

## Verification
A corrupt pointer or register shows on `cfg_o` on the clock edge after the write that caused it. A wrong readback decision shows on `rdata_o` or `rdata_vld_o` in the same cycle as the read. The bench therefore checks every register immediately after each write. It then sweeps all eight variant codes against all 32 pointer values on both read ports. Any misplaced mask bit, wrong variant branch or stray decode is caught on the first access that touches it.

// File: rtl/crtc_regif_pkg.sv
package crtc_regif_pkg;

  localparam int NREG  = 18;
  localparam int LP_HI = 16;
  localparam int LP_LO = 17;

  typedef enum logic [1:0] {
    FN_IDX  = 2'b00,
    FN_DWR  = 2'b01,
    FN_STAT = 2'b10,
    FN_DRD  = 2'b11
  } port_fn_e;

  // implemented-bit mask of each configuration register
  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0, 1, 2, 3, 13: reg_mask = 8'hFF;
      5, 9, 11:       reg_mask = 8'h1F;
      12, 14, 16:     reg_mask = 8'h3F;
      4, 6, 7, 10:    reg_mask = 8'h7F;
      8:              reg_mask = 8'h03;
      15, 17:         reg_mask = 8'hFF;
      default:        reg_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/crtc_port_dec.sv
module crtc_port_dec
  import crtc_regif_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CS_BIT = 14,
  parameter int FN_LSB = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic          idx_we_o,
  output logic          dat_we_o,
  output logic          stat_re_o,
  output logic          dat_re_o
);

  logic     sel;
  port_fn_e fn;

  assign sel = ~addr_i[CS_BIT];
  assign fn  = port_fn_e'(addr_i[FN_LSB +: 2]);

  assign idx_we_o  = sel & wr_en_i & (fn == FN_IDX);
  assign dat_we_o  = sel & wr_en_i & (fn == FN_DWR);
  assign stat_re_o = sel & rd_en_i & (fn == FN_STAT);
  assign dat_re_o  = sel & rd_en_i & (fn == FN_DRD);

endmodule

// File: rtl/crtc_reg_file.sv
module crtc_reg_file
  import crtc_regif_pkg::*;
#(
  parameter int DW  = 8,
  parameter int IW  = 5,
  parameter int LPW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              lp_strobe_i,
  input  logic [LPW-1:0]    lp_addr_i,
  output logic [IW-1:0]     idx_o,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int LP_PAD = 2 * DW - LPW;

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)           idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i[IW-1:0];
  end

  assign idx_o = idx_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] q;
    if (r == LP_HI) begin : g_lp_hi
      always_ff @(posedge clk) begin
        if (rst)              q <= '0;
        else if (lp_strobe_i) q <= {{LP_PAD{1'b0}}, lp_addr_i[LPW-1:DW]};
      end
    end else if (r == LP_LO) begin : g_lp_lo
      always_ff @(posedge clk) begin
        if (rst)              q <= '0;
        else if (lp_strobe_i) q <= lp_addr_i[DW-1:0];
      end
    end else begin : g_cfg
      localparam logic [DW-1:0] MASK = DW'(reg_mask(r));
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (dat_we_i && idx_q == IW'(r)) q <= wdata_i & MASK;
      end
    end
    assign regs_o[r*DW +: DW] = q;
  end

endmodule

// File: rtl/crtc_read_mux.sv
module crtc_read_mux
  import crtc_regif_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input  logic [2:0]         variant_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [NREG*DW-1:0] regs_i,
  input  logic               stat_re_i,
  input  logic               dat_re_i,
  output logic [DW-1:0]      rdata_o,
  output logic               vld_o
);

  logic [2:0]    vv;
  logic [DW-1:0] cur;
  logic [DW-1:0] d_val;
  logic          d_ok;

  assign vv = (variant_i > 3'd4) ? 3'd0 : variant_i;

  always_comb begin
    cur = '0;
    for (int r = 0; r < NREG; r++)
      if (idx_i == IW'(r)) cur = regs_i[r*DW +: DW];
  end

  // data-port view of the selected register
  always_comb begin
    d_val = '0;
    d_ok  = 1'b0;
    if (idx_i <= IW'(11)) begin
      d_ok = (vv <= 3'd1);
    end else if (idx_i <= IW'(13)) begin
      d_ok = 1'b1;
      if (vv != 3'd1 && vv != 3'd2) d_val = cur;
    end else if (idx_i < IW'(NREG)) begin
      d_ok  = 1'b1;
      d_val = cur;
    end else begin
      d_ok = (vv <= 3'd2);
      if (idx_i == '1 && vv == 3'd1) d_val = '1;
    end
  end

  always_comb begin
    rdata_o = '0;
    vld_o   = 1'b0;
    if (dat_re_i) begin
      vld_o   = d_ok;
      rdata_o = d_ok ? d_val : '0;
    end else if (stat_re_i) begin
      if (vv == 3'd1) begin
        vld_o = 1'b1;
      end else if (vv >= 3'd3) begin
        vld_o   = d_ok;
        rdata_o = d_ok ? d_val : '0;
      end
    end
  end

endmodule

// File: rtl/crtc_regif.sv
module crtc_regif
  import crtc_regif_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int IW     = 5,
  parameter int LPW    = 14,
  parameter int CS_BIT = 14,
  parameter int FN_LSB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         variant_i,
  input  logic [AW-1:0]      port_addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rdata_vld_o,
  input  logic               lp_strobe_i,
  input  logic [LPW-1:0]     lp_addr_i,
  output logic [NREG*DW-1:0] cfg_o
);

  logic          idx_we, dat_we, stat_re, dat_re;
  logic [IW-1:0] idx;

  crtc_port_dec #(.AW(AW), .CS_BIT(CS_BIT), .FN_LSB(FN_LSB)) u_dec (
    .addr_i    (port_addr_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .idx_we_o  (idx_we),
    .dat_we_o  (dat_we),
    .stat_re_o (stat_re),
    .dat_re_o  (dat_re)
  );

  crtc_reg_file #(.DW(DW), .IW(IW), .LPW(LPW)) u_rf (
    .clk         (clk),
    .rst         (rst),
    .idx_we_i    (idx_we),
    .dat_we_i    (dat_we),
    .wdata_i     (wdata_i),
    .lp_strobe_i (lp_strobe_i),
    .lp_addr_i   (lp_addr_i),
    .idx_o       (idx),
    .regs_o      (cfg_o)
  );

  crtc_read_mux #(.DW(DW), .IW(IW)) u_rd (
    .variant_i (variant_i),
    .idx_i     (idx),
    .regs_i    (cfg_o),
    .stat_re_i (stat_re),
    .dat_re_i  (dat_re),
    .rdata_o   (rdata_o),
    .vld_o     (rdata_vld_o)
  );

endmodule

// File: rtl/crtc_regif_chk.sv
module crtc_regif_chk
  import crtc_regif_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int LPW    = 14,
  parameter int CS_BIT = 14
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      port_addr_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [DW-1:0]      rdata_o,
  input logic               rdata_vld_o,
  input logic               lp_strobe_i,
  input logic [NREG*DW-1:0] cfg_o
);

  // R1
  cs_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && port_addr_i[CS_BIT] && !lp_strobe_i) |=> $stable(cfg_o));

  // R1
  cs_read_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && port_addr_i[CS_BIT]) |-> !rdata_vld_o);

  // R3
  narrow_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_o[8*DW+2 +: 6] == '0) && (cfg_o[12*DW+6 +: 2] == '0) &&
    (cfg_o[9*DW+5 +: 3] == '0) && (cfg_o[4*DW+7] == 1'b0));

  // R4
  lp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_strobe_i |=> $stable(cfg_o[LP_HI*DW +: 2*DW]));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cfg_o == '0));

  // R10
  idle_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |-> !rdata_vld_o);

  // R12
  invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rdata_vld_o |-> (rdata_o == '0));

endmodule

bind crtc_regif crtc_regif_chk #(.AW(AW), .DW(DW), .LPW(LPW), .CS_BIT(CS_BIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_addr_i (port_addr_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rdata_o     (rdata_o),
  .rdata_vld_o (rdata_vld_o),
  .lp_strobe_i (lp_strobe_i),
  .cfg_o       (cfg_o)
);

// File: tb/crtc_regif_tb.sv
module crtc_regif_tb;

  localparam logic [15:0] P_IDX  = 16'hBC00;
  localparam logic [15:0] P_DWR  = 16'hBD00;
  localparam logic [15:0] P_STAT = 16'hBE00;
  localparam logic [15:0] P_DRD  = 16'hBF00;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   variant = 3'd0;
  logic [15:0]  port_addr = 16'h0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [7:0]   wdata = 8'h0;
  logic [7:0]   rdata;
  logic         rvld;
  logic         lp_strobe = 1'b0;
  logic [13:0]  lp_addr = 14'h0;
  logic [143:0] cfg;

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [18];

  always #10 clk = ~clk;

  crtc_regif u_dut (
    .clk(clk), .rst(rst), .variant_i(variant), .port_addr_i(port_addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .rdata_vld_o(rvld), .lp_strobe_i(lp_strobe), .lp_addr_i(lp_addr), .cfg_o(cfg)
  );

  function automatic logic [7:0] width_mask(input int r);
    int w;
    case (r)
      5, 9, 11:       w = 5;
      12, 14, 16:     w = 6;
      4, 6, 7, 10:    w = 7;
      8:              w = 2;
      default:        w = 8;
    endcase
    return 8'((1 << w) - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    port_addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    port_addr = a; rd_en = 1'b1;
    #2;
    d = rdata; v = rvld;
    rd_en = 1'b0;
  endtask

  task automatic check_cfg(input string req);
    for (int r = 0; r < 18; r++)
      check(cfg[r*8 +: 8] == mdl[r], req, cfg[r*8 +: 8], mdl[r]);
  endtask

  // expected readback from the requirement table
  task automatic expect_rd(input int v, input int idx, input bit stat,
                           output logic [7:0] d, output logic ok);
    int vv = (v > 4) ? 0 : v;
    d = 8'h00; ok = 1'b0;
    if (stat && (vv == 0 || vv == 2)) return;
    if (stat && vv == 1) begin ok = 1'b1; return; end
    if (idx <= 11)       ok = (vv <= 1);
    else if (idx <= 13) begin ok = 1'b1; if (vv != 1 && vv != 2) d = mdl[idx]; end
    else if (idx <= 17) begin ok = 1'b1; d = mdl[idx]; end
    else begin
      ok = (vv <= 2);
      if (idx == 31 && vv == 1) d = 8'hFF;
    end
  endtask

  initial begin
    logic [7:0] d, ed;
    logic v, ev;
    for (int r = 0; r < 18; r++) mdl[r] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check_cfg("R10");
    check(rvld == 1'b0, "R10", rvld, 0);

    // R3 R11 masks with all-ones, then a pattern; R4 writes to 16/17 ignored
    for (int r = 0; r < 18; r++) begin
      bus_wr(P_IDX, 8'(r));
      bus_wr(P_DWR, 8'hFF);
      if (r < 16) mdl[r] = width_mask(r);
      check_cfg((r < 16) ? "R3" : "R4");
    end
    for (int r = 0; r < 18; r++) begin
      bus_wr(P_IDX, 8'(r));
      bus_wr(P_DWR, 8'(r * 37 + 8'h5B));
      if (r < 16) mdl[r] = 8'(r * 37 + 8'h5B) & width_mask(r);
    end
    check_cfg("R11");

    // R2 pointer keeps low five bits
    bus_wr(P_IDX, 8'hE3);
    bus_wr(P_DWR, 8'h5A);
    mdl[3] = 8'h5A;
    check_cfg("R2");

    // R4 light-pen capture, then processor write still ignored
    @(negedge clk); lp_addr = 14'h3ABC; lp_strobe = 1'b1;
    @(negedge clk); lp_strobe = 1'b0;
    mdl[16] = 8'h3A; mdl[17] = 8'hBC;
    check_cfg("R4");
    bus_wr(P_IDX, 8'd16); bus_wr(P_DWR, 8'h00);
    bus_wr(P_IDX, 8'd17); bus_wr(P_DWR, 8'h00);
    check_cfg("R4");

    // R1 chip select high blocks writes and reads
    bus_wr(P_IDX, 8'd0);
    bus_wr(16'hFD00, 8'h00);
    bus_wr(16'h4100, 8'h11);
    check_cfg("R1");
    variant = 3'd0;
    bus_rd(16'hFF00, d, v);
    check(v == 1'b0 && d == 8'h00, "R1", {v, d}, 0);
    bus_rd(P_IDX, d, v);
    check(v == 1'b0, "R1", v, 0);
    bus_rd(P_DWR, d, v);
    check(v == 1'b0, "R1", v, 0);

    // R5-R9 R12 sweep of variants, pointer values and both read ports
    for (int vr = 0; vr < 8; vr++) begin
      variant = 3'(vr);
      for (int i = 0; i < 32; i++) begin
        bus_wr(P_IDX, 8'(i));
        for (int s = 0; s < 2; s++) begin
          expect_rd(vr, i, s[0], ed, ev);
          bus_rd(s[0] ? P_STAT : P_DRD, d, v);
          if (s == 1)
            check(v == ev && d == ed, "R9", {v, d}, {ev, ed});
          else if (i <= 11)
            check(v == ev && d == ed, "R5", {v, d}, {ev, ed});
          else if (i <= 13)
            check(v == ev && d == ed, "R6", {v, d}, {ev, ed});
          else if (i <= 17)
            check(v == ev && d == ed, "R7", {v, d}, {ev, ed});
          else if (vr > 4)
            check(v == ev && d == ed, "R12", {v, d}, {ev, ed});
          else
            check(v == ev && d == ed, "R8", {v, d}, {ev, ed});
        end
      end
    end

    // R10 reset in mid-run clears everything including the pointer
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 18; r++) mdl[r] = 8'h00;
    check_cfg("R10");
    variant = 3'd0;
    bus_wr(P_DWR, 8'h77);
    mdl[0] = 8'h77;
    check_cfg("R10");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule